// File: doc/BRIEF.md
# Double-Buffered Operand Bank Handoff

This block holds two operand register files, A and B. Each file has two banks of 64 rows by 16 columns, and each datum is 19 bits wide. Every bank carries one ownership flag, so at any moment it belongs either to the loading side (the producer) or to the compute side (the consumer). The producer writes single datums, zero-fills whole banks, and hands filled banks over with a set-valid command. The consumer reads whole rows from the bank it currently holds and then releases that bank back to the producer.

Each side keeps its own current-bank pointer per file. This lets the producer fill one bank while the consumer works on the other. When a side tries to touch a bank it does not own, the block raises a stall output for that cycle and performs nothing. The requester holds its command until the stall clears.

Top module: `opnd_bank_xchg`

## Requirements
- R1: After a synchronous reset, all four banks are owned by the producer and both pointers of both files select bank 0. A consumer read of either file stalls, and a producer write proceeds.
- R2: An accepted write stores `prd_data` at (`prd_row`, `prd_col`) in the producer's current bank of the file `prd_file` selects (0 = A, 1 = B). After handoff, the consumer reads that value back in column slice `cons_rd_data[19*col +: 19]`.
- R3: `prd_op` encodes the producer command: 0 idle, 1 write, 2 zero-fill, 3 set-valid. A command is accepted in a cycle where it is not idle and `prd_stall` is low.
- R4: A write or zero-fill aimed at a file whose producer-current bank is owned by the consumer raises `prd_stall` in the same cycle and has no effect.
- R5: Set-valid uses `prd_mask`, where bit 0 selects A and bit 1 selects B. It gives each selected file's producer-current bank to the consumer and moves that file's producer pointer to the other bank. If any selected bank is not producer-owned, the whole command stalls. A mask of 0 does nothing and does not stall.
- R6: A consumer read with `cons_rd_en` of a bank the consumer owns returns the full 16-column row one cycle later, with `cons_rd_vld` high. Otherwise `cons_stall` is high, and `cons_rd_vld` stays low in the next cycle.
- R7: A release with `cons_rel_en` acts on each file selected in `cons_rel_mask` (bit 0 = A, bit 1 = B). If the consumer owns its current bank of that file, the bank returns to the producer and the consumer pointer moves to the other bank.
- R8: A file whose bit is set in `cons_rel_hold` is not affected by a release: its ownership and consumer pointer stay the same.
- R9: A zero-fill clears all 64 rows of the producer-current bank of the selected file over the 64 cycles after acceptance. During those cycles every non-idle producer command stalls, which keeps later commands in order behind it.
- R10: `prd_row` is 7 bits wide. For file B the row is taken modulo 64. For file A, a write with row 64 or above is dropped.
- R11: While the consumer holds one bank of a file, the producer can fill the other bank. A second handoff of the same file stalls until the consumer releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prd_op | input | 2 | Producer command (0 idle, 1 write, 2 zero, 3 set-valid) |
| prd_file | input | 1 | File for write or zero (0 = A, 1 = B) |
| prd_row | input | 7 | Write row (B wraps modulo 64, A drops rows of 64 and above) |
| prd_col | input | 4 | Write column |
| prd_data | input | 19 | Write datum |
| prd_mask | input | 2 | Set-valid file mask |
| prd_stall | output | 1 | Producer command not accepted this cycle |
| cons_rd_en | input | 1 | Consumer row read request |
| cons_rd_file | input | 1 | File to read |
| cons_rd_row | input | 6 | Row to read |
| cons_stall | output | 1 | Consumer read not accepted this cycle |
| cons_rd_vld | output | 1 | Read data valid (one cycle after acceptance) |
| cons_rd_data | output | 304 | 16 datums of the row, column c at bits 19c+18:19c |
| cons_rel_en | input | 1 | Consumer release request |
| cons_rel_mask | input | 2 | Files to release |
| cons_rel_hold | input | 2 | Per-file release suppression |

## Verification
A wrong ownership flag or pointer does not stay hidden. It shows up in the same cycle as an unexpected level on `prd_stall` or `cons_stall`, on the next command that touches that file. A wrong bank select shows up one cycle after a read, as row data that belongs to the other bank. A zero-fill sequencer that is off by one or that ends too early shows up as a stall window of the wrong length, or as a nonzero row 63. The bench keeps a reference model of flags, pointers and contents, and compares every stall and every read against it.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_ZERO   = 2'd2,
    OP_SETVLD = 2'd3
  } prd_op_e;
endpackage

// File: rtl/opnd_col_ram.sv
// One column of one operand file: both banks stacked, one write and one read port.
module opnd_col_ram #(
  parameter int DW = 19,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q <= mem[ra];
  end
endmodule

// File: rtl/opnd_file.sv
// One operand file: two banks of ROWS x COLS datums, row-wide registered read.
module opnd_file #(
  parameter int ROWS = 64,
  parameter int COLS = 16,
  parameter int DW   = 19,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_all,
  input  logic               wr_one,
  input  logic               wr_bank,
  input  logic [ROW_W-1:0]   wr_row,
  input  logic [COL_W-1:0]   wr_col,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic               rd_bank,
  input  logic [ROW_W-1:0]   rd_row,
  output logic [COLS*DW-1:0] rd_data
);
  localparam int AW = ROW_W + 1;

  logic [AW-1:0] wa, ra;
  logic [DW-1:0] wd;
  assign wa = {wr_bank, wr_row};
  assign ra = {rd_bank, rd_row};
  assign wd = wr_all ? '0 : wr_data;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic we_c;
    assign we_c = wr_all | (wr_one & (wr_col == COL_W'(c)));
    opnd_col_ram #(.DW(DW), .AW(AW)) u_ram (
      .clk (clk),
      .we  (we_c),
      .wa  (wa),
      .wd  (wd),
      .re  (rd_en),
      .ra  (ra),
      .q   (rd_data[c*DW +: DW])
    );
  end

  // R11: producer and consumer never touch the same bank in one cycle
  sep_bank_chk: assert property (@(posedge clk) disable iff (rst)
    ((wr_all || wr_one) && rd_en) |-> (wr_bank != rd_bank));
endmodule

// File: rtl/opnd_owner_ctl.sv
// Ownership flags and side pointers for the two banks of one file.
module opnd_owner_ctl (
  input  logic clk,
  input  logic rst,
  input  logic hand_en,
  input  logic rel_en,
  input  logic rel_hold,
  output logic prd_bank,
  output logic cons_bank,
  output logic prd_owns,
  output logic cons_owns
);
  logic [1:0] cons_own;

  assign prd_owns  = ~cons_own[prd_bank];
  assign cons_owns = cons_own[cons_bank];

  always_ff @(posedge clk) begin
    if (rst) begin
      cons_own  <= '0;
      prd_bank  <= 1'b0;
      cons_bank <= 1'b0;
    end else begin
      if (hand_en) begin
        cons_own[prd_bank] <= 1'b1;
        prd_bank           <= ~prd_bank;
      end
      if (rel_en && !rel_hold && cons_own[cons_bank]) begin
        cons_own[cons_bank] <= 1'b0;
        cons_bank           <= ~cons_bank;
      end
    end
  end

  // R5
  hand_flip_chk: assert property (@(posedge clk) disable iff (rst)
    hand_en |=> (prd_bank != $past(prd_bank)));
  // R5
  hand_only_owned_chk: assert property (@(posedge clk) disable iff (rst)
    hand_en |-> prd_owns);
  // R7
  rel_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && !rel_hold && cons_owns) |=> (cons_bank != $past(cons_bank)));
  // R8
  rel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_en && rel_hold && !hand_en) |=> ($stable(cons_bank) && $stable(cons_own)));
endmodule

// File: rtl/opnd_bank_xchg.sv
module opnd_bank_xchg
  import opnd_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 16,
  parameter int DW   = 19,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int NF    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         prd_op,
  input  logic               prd_file,
  input  logic [ROW_W:0]     prd_row,
  input  logic [COL_W-1:0]   prd_col,
  input  logic [DW-1:0]      prd_data,
  input  logic [NF-1:0]      prd_mask,
  output logic               prd_stall,
  input  logic               cons_rd_en,
  input  logic               cons_rd_file,
  input  logic [ROW_W-1:0]   cons_rd_row,
  output logic               cons_stall,
  output logic               cons_rd_vld,
  output logic [COLS*DW-1:0] cons_rd_data,
  input  logic               cons_rel_en,
  input  logic [NF-1:0]      cons_rel_mask,
  input  logic [NF-1:0]      cons_rel_hold
);
  prd_op_e op;
  assign op = prd_op_e'(prd_op);

  logic [NF-1:0] pbank, cbank, p_owns, c_owns, hand_en, rel_en;
  logic [COLS*DW-1:0] rdata [NF];

  // zero-fill sequencer
  logic             zbusy, zfile, zbank;
  logic [ROW_W-1:0] zrow;

  logic blk_file, blk_mask, go, wr_go, rd_go, rd_file_q;
  assign blk_file  = ~p_owns[prd_file];
  assign blk_mask  = |(prd_mask & ~p_owns);
  assign prd_stall = (op != OP_IDLE) &&
                     (zbusy ||
                      ((op == OP_WRITE || op == OP_ZERO) && blk_file) ||
                      (op == OP_SETVLD && blk_mask));
  assign go    = (op != OP_IDLE) && !prd_stall;
  assign wr_go = go && (op == OP_WRITE) && (prd_file || !prd_row[ROW_W]);

  assign cons_stall = cons_rd_en && !c_owns[cons_rd_file];
  assign rd_go      = cons_rd_en && !cons_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      zbusy <= 1'b0;
      zfile <= 1'b0;
      zbank <= 1'b0;
      zrow  <= '0;
    end else if (zbusy) begin
      zrow <= zrow + 1'b1;
      if (zrow == ROW_W'(ROWS - 1)) zbusy <= 1'b0;
    end else if (go && op == OP_ZERO) begin
      zbusy <= 1'b1;
      zfile <= prd_file;
      zbank <= pbank[prd_file];
      zrow  <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cons_rd_vld <= 1'b0;
      rd_file_q   <= 1'b0;
    end else begin
      cons_rd_vld <= rd_go;
      if (rd_go) rd_file_q <= cons_rd_file;
    end
  end

  assign cons_rd_data = rdata[rd_file_q];

  for (genvar f = 0; f < NF; f++) begin : g_file
    logic             z_here, w_here;
    logic             w_bank;
    logic [ROW_W-1:0] w_row;
    assign z_here = zbusy && (zfile == 1'(f));
    assign w_here = wr_go && (prd_file == 1'(f));
    assign w_bank = z_here ? zbank : pbank[f];
    assign w_row  = z_here ? zrow  : prd_row[ROW_W-1:0];
    assign hand_en[f] = go && (op == OP_SETVLD) && prd_mask[f];
    assign rel_en[f]  = cons_rel_en && cons_rel_mask[f];

    opnd_owner_ctl u_own (
      .clk       (clk),
      .rst       (rst),
      .hand_en   (hand_en[f]),
      .rel_en    (rel_en[f]),
      .rel_hold  (cons_rel_hold[f]),
      .prd_bank  (pbank[f]),
      .cons_bank (cbank[f]),
      .prd_owns  (p_owns[f]),
      .cons_owns (c_owns[f])
    );

    opnd_file #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_file (
      .clk     (clk),
      .rst     (rst),
      .wr_all  (z_here),
      .wr_one  (w_here),
      .wr_bank (w_bank),
      .wr_row  (w_row),
      .wr_col  (prd_col),
      .wr_data (prd_data),
      .rd_en   (rd_go && (cons_rd_file == 1'(f))),
      .rd_bank (cbank[f]),
      .rd_row  (cons_rd_row),
      .rd_data (rdata[f])
    );
  end

  // R9
  zero_end_chk: assert property (@(posedge clk) disable iff (rst)
    (zbusy && zrow == ROW_W'(ROWS - 1)) |=> !zbusy);
  // R9
  zero_block_chk: assert property (@(posedge clk) disable iff (rst)
    (zbusy && op != OP_IDLE) |-> prd_stall);
  // R6
  rd_vld_chk: assert property (@(posedge clk) disable iff (rst)
    (cons_rd_en && cons_stall) |=> !cons_rd_vld);
endmodule

// File: tb/opnd_bank_xchg_bench.sv
module opnd_bank_xchg_bench;
  localparam int ROWS = 64, COLS = 16, DW = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0] prd_op = '0;
  logic prd_file = 1'b0;
  logic [6:0] prd_row = '0;
  logic [3:0] prd_col = '0;
  logic [DW-1:0] prd_data = '0;
  logic [1:0] prd_mask = '0;
  logic prd_stall;
  logic cons_rd_en = 1'b0, cons_rd_file = 1'b0;
  logic [5:0] cons_rd_row = '0;
  logic cons_stall, cons_rd_vld;
  logic [COLS*DW-1:0] cons_rd_data;
  logic cons_rel_en = 1'b0;
  logic [1:0] cons_rel_mask = '0, cons_rel_hold = '0;

  opnd_bank_xchg u_opnd_bank_xchg (
    .clk(clk), .rst(rst), .prd_op(prd_op), .prd_file(prd_file), .prd_row(prd_row),
    .prd_col(prd_col), .prd_data(prd_data), .prd_mask(prd_mask), .prd_stall(prd_stall),
    .cons_rd_en(cons_rd_en), .cons_rd_file(cons_rd_file), .cons_rd_row(cons_rd_row),
    .cons_stall(cons_stall), .cons_rd_vld(cons_rd_vld), .cons_rd_data(cons_rd_data),
    .cons_rel_en(cons_rel_en), .cons_rel_mask(cons_rel_mask), .cons_rel_hold(cons_rel_hold));

  int checks = 0, errors = 0, cyc = 0, zend = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  logic [DW-1:0] mdl [2][2][ROWS][COLS];
  bit kn [2][2][ROWS][COLS];
  bit cown [2][2];
  bit pb [2], cb [2];

  task automatic chk(input string req, input bit ok, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_pstall(input int op, input int f, input bit [1:0] m);
    if (op == 0) return 0;
    if (cyc < zend) return 1;
    if (op == 1 || op == 2) return cown[f][pb[f]];
    for (int i = 0; i < 2; i++) if (m[i] && cown[i][pb[i]]) return 1;
    return 0;
  endfunction

  task automatic do_prd(input string req, input int op, input int f, input int row,
                        input int col, input logic [DW-1:0] d, input bit [1:0] m);
    bit es;
    @(negedge clk);
    prd_op = 2'(op); prd_file = f[0]; prd_row = 7'(row); prd_col = 4'(col);
    prd_data = d; prd_mask = m;
    #1;
    es = exp_pstall(op, f, m);
    chk(req, prd_stall == es, "prd_stall", 64'(prd_stall), 64'(es));
    if (!es) begin
      if (op == 1) begin
        if (f == 1 || row < 64) begin
          mdl[f][pb[f]][row % 64][col] = d; kn[f][pb[f]][row % 64][col] = 1;
        end
      end else if (op == 2) begin
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++) begin
            mdl[f][pb[f]][r][c] = '0; kn[f][pb[f]][r][c] = 1;
          end
        zend = cyc + 1 + ROWS;
      end else if (op == 3) begin
        for (int i = 0; i < 2; i++) if (m[i]) begin cown[i][pb[i]] = 1; pb[i] = ~pb[i]; end
      end
    end
    @(negedge clk);
    prd_op = '0;
  endtask

  task automatic do_rd(input string req, input int f, input int row);
    bit es;
    int bad;
    logic [COLS*DW-1:0] ev;
    @(negedge clk);
    cons_rd_en = 1'b1; cons_rd_file = f[0]; cons_rd_row = 6'(row);
    #1;
    es = !cown[f][cb[f]];
    chk(req, cons_stall == es, "cons_stall", 64'(cons_stall), 64'(es));
    @(negedge clk);
    cons_rd_en = 1'b0;
    #1;
    chk(req, cons_rd_vld == !es, "cons_rd_vld", 64'(cons_rd_vld), 64'(!es));
    if (!es) begin
      bad = 0; ev = cons_rd_data;
      for (int c = 0; c < COLS; c++)
        if (kn[f][cb[f]][row][c]) begin
          ev[c*DW +: DW] = mdl[f][cb[f]][row][c];
          if (cons_rd_data[c*DW +: DW] !== mdl[f][cb[f]][row][c]) bad++;
        end
      checks++;
      if (bad != 0) begin
        errors++;
        $display("FAIL %s row data file %0d row %0d: actual %h expected %h",
                 req, f, row, cons_rd_data, ev);
      end
    end
  endtask

  task automatic do_rel(input bit [1:0] m, input bit [1:0] h);
    @(negedge clk);
    cons_rel_en = 1'b1; cons_rel_mask = m; cons_rel_hold = h;
    for (int i = 0; i < 2; i++)
      if (m[i] && !h[i] && cown[i][cb[i]]) begin cown[i][cb[i]] = 0; cb[i] = ~cb[i]; end
    @(negedge clk);
    cons_rel_en = 1'b0;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    for (int f = 0; f < 2; f++) begin
      pb[f] = 0; cb[f] = 0;
      for (int b = 0; b < 2; b++) begin
        cown[f][b] = 0;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++) kn[f][b][r][c] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    do_rd("R1", 0, 0);
    do_rd("R1", 1, 0);
    // R9: zero-fill, then R3/R9: a write right behind it stalls
    do_prd("R9", 2, 0, 0, 0, '0, 2'b00);
    do_prd("R9", 1, 0, 1, 1, 19'h1, 2'b00);
    repeat (ROWS) @(negedge clk);
    do_prd("R9", 2, 1, 0, 0, '0, 2'b00);
    repeat (ROWS + 1) @(negedge clk);
    // R2 / R3 / R10
    do_prd("R2", 1, 0, 5, 3, 19'h5a5a5, 2'b00);
    do_prd("R10", 1, 1, 70, 15, 19'h7beef, 2'b00);
    do_prd("R10", 1, 0, 70, 2, 19'h12345, 2'b00);
    do_prd("R3", 0, 0, 9, 9, 19'h11111, 2'b00);
    // R5: hand over both files
    do_prd("R5", 3, 0, 0, 0, '0, 2'b11);
    do_rd("R2", 0, 5);
    do_rd("R10", 0, 6);
    do_rd("R10", 1, 6);
    do_rd("R9", 1, 63);
    // R11: producer fills other bank while consumer holds
    do_prd("R11", 1, 0, 7, 7, 19'h0abcd, 2'b00);
    do_prd("R5", 3, 0, 0, 0, '0, 2'b01);
    do_prd("R4", 1, 0, 1, 1, 19'h3, 2'b00);
    do_prd("R4", 2, 0, 0, 0, '0, 2'b00);
    do_prd("R11", 1, 1, 8, 0, 19'h44444, 2'b00);
    do_prd("R5", 3, 0, 0, 0, '0, 2'b11);
    do_prd("R5", 3, 0, 0, 0, '0, 2'b00);
    // R8: held release changes nothing
    do_rel(2'b01, 2'b01);
    do_prd("R8", 1, 0, 1, 1, 19'h3, 2'b00);
    do_rd("R8", 0, 5);
    // R7: release returns bank
    do_rel(2'b01, 2'b00);
    do_prd("R7", 1, 0, 1, 1, 19'h3, 2'b00);
    do_rd("R7", 0, 7);
    // R6: read of a not-owned bank stalls
    do_rel(2'b10, 2'b00);
    do_rd("R6", 1, 6);

    // random phase
    for (int it = 0; it < 1500; it++) begin
      int k;
      k = $urandom_range(0, 99);
      if (k < 40)
        do_prd("R2", 1, $urandom_range(0, 1), $urandom_range(0, 127), $urandom_range(0, 15),
               19'($urandom), 2'($urandom_range(0, 3)));
      else if (k < 52)
        do_prd("R5", 3, 0, 0, 0, '0, 2'($urandom_range(0, 3)));
      else if (k < 54)
        do_prd("R9", 2, $urandom_range(0, 1), 0, 0, '0, 2'b00);
      else if (k < 82)
        do_rd("R6", $urandom_range(0, 1), $urandom_range(0, 63));
      else
        do_rel(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule